// File: doc/BRIEF.md
# Serial Flash Command Phase Decoder

This block follows a serial flash transaction from the host side, one received byte at a time. A small table is loaded beforehand. Each entry ties an 8-bit opcode to four things: how its address is sized, whether it writes or reads, how many data lanes the data phase uses, and how many idle cycles come before the data. The table is written one entry per cycle through a programming port. A second entry for an opcode already in the table is refused. So is an entry with an illegal lane code, and so is any entry once every slot is full. A refusal raises an error pulse.

During a transaction the first byte received after chip-select goes low is taken as the opcode. It is compared against every valid entry at once. The decoder then moves through the opcode, address, dummy and data phases, skipping any phase of zero length. On the way it builds the address from the bytes it receives. Through the data phase it reports the lane count and the direction. An opcode with no matching entry is treated as a write with one lane, no address and no dummy cycles. Serial bit sampling is done elsewhere; this block only sees whole bytes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, phase is 0 (idle), addrOut is 0, dataLanes is 1, isWrite is 0, progErr is 0 and the table is empty.
- R2: Phase codes are idle=0, opcode=1, address=2, dummy=3, data=4. In idle with csN low, phase is 1 on the next cycle. With csN high, phase is 0 on the next cycle, whatever phase it was in.
- R3: A programming write whose opcode matches a valid entry is refused. progErr is 1 on the cycle after the write, and the existing entry still decides lookups. An accepted write gives progErr 0.
- R4: The table holds DEPTH (16) entries. A write when all of them are valid is refused with progErr.
- R5: Lane code 0 means 1 lane, 1 means 2 lanes, 2 means 4 lanes. A write with code 3 is refused with progErr, and the table is left unchanged.
- R6: Address mode code 0 gives no address bytes, code 2 gives 3 bytes and code 3 gives 4 bytes. With no address bytes the decoder leaves the opcode phase straight for the dummy phase, or for the data phase if the dummy count is also 0.
- R7: Address mode code 1 gives 4 address bytes when addr4bEn is high at the moment the opcode byte is accepted, and 3 bytes when it is low.
- R8: Accepting an opcode clears addrOut. Each address byte then shifts in at the low end, most significant byte first, so a 3-byte address ends up right-aligned with zeros above it.
- R9: The dummy phase lasts exactly as many clock cycles as the entry's dummy count. With a count of 0 it does not occur.
- R10: An opcode with no valid matching entry gives isWrite 1 and dataLanes 1, and goes directly to the data phase.
- R11: From the opcode until the next opcode, dataLanes gives the matched entry's lane count as 1, 2 or 4, and isWrite gives its write bit.
- R12: A byteValid strobe in the idle, dummy or data phase leaves addrOut and phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| progEn | input | 1 | Write one table entry this cycle |
| progOpcode | input | 8 | Opcode of the entry being written |
| progAddrMode | input | 2 | Address mode: 0 none, 1 switched, 2 three bytes, 3 four bytes |
| progWrite | input | 1 | Write-direction bit of the entry |
| progLanes | input | 2 | Lane code: 0=1, 1=2, 2=4, 3 illegal |
| progDummy | input | DUMMY_W (5) | Dummy cycle count of the entry |
| progErr | output | 1 | Pulses one cycle after a refused table write |
| csN | input | 1 | Active-low chip select |
| byteValid | input | 1 | A received byte is present on byteData |
| byteData | input | 8 | Received byte |
| addr4bEn | input | 1 | Global 4-byte address enable for switched mode |
| phase | output | 3 | Current phase code |
| addrOut | output | 32 | Collected address, right-aligned |
| dataLanes | output | 3 | Lane count for the data phase (1, 2 or 4) |
| isWrite | output | 1 | Direction of the current command |

## Verification
The assertions rely on the table never holding two valid entries with the same opcode, so at most one compare line matches. The only way to write the table is through the refusing programming port, and the stimulus includes a duplicate opcode to exercise that refusal. The properties also expect every transaction to begin with csN going high and then low again, and the bench always ends a transaction by raising csN for at least one cycle. Input changes are made only on the falling clock edge, so each byte strobe is seen by exactly one rising edge. The dummy phase is counted in core clock cycles, on the assumption of one serial clock per core clock.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_OPCODE = 3'd1,
    PH_ADDR   = 3'd2,
    PH_DUMMY  = 3'd3,
    PH_DATA   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    AM_NONE     = 2'd0,
    AM_SWITCHED = 2'd1,
    AM_THREE    = 2'd2,
    AM_FOUR     = 2'd3
  } addr_mode_e;

  localparam logic [1:0] LANE_CODE_BAD = 2'd3;

  typedef struct packed {
    logic latchCmd;
    logic shiftAddr;
    logic tickDummy;
  } strobe_t;

endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_cmd_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               progEn,
  input  logic [7:0]         progOpcode,
  input  logic [1:0]         progAddrMode,
  input  logic               progWrite,
  input  logic [1:0]         progLanes,
  input  logic [DUMMY_W-1:0] progDummy,
  output logic               progErr,
  input  logic [7:0]         lkOpcode,
  output logic [DEPTH-1:0]   hitVec,
  output logic               lkHit,
  output logic [1:0]         lkMode,
  output logic               lkWrite,
  output logic [1:0]         lkLanes,
  output logic [DUMMY_W-1:0] lkDummy
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]   entValid;
  logic [7:0]         entOp    [DEPTH];
  logic [1:0]         entMode  [DEPTH];
  logic               entWrite [DEPTH];
  logic [1:0]         entLanes [DEPTH];
  logic [DUMMY_W-1:0] entDummy [DEPTH];

  logic             dupHit;
  logic             freeFound;
  logic [IDX_W-1:0] freeIdx;
  logic             reject;

  // Duplicate detection and first free slot, both in parallel over the table.
  always_comb begin
    dupHit    = 1'b0;
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entValid[i] && entOp[i] == progOpcode) dupHit = 1'b1;
      if (!entValid[i] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  assign reject = dupHit || !freeFound || (progLanes == LANE_CODE_BAD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progErr  <= 1'b0;
      entValid <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entOp[i]    <= '0;
        entMode[i]  <= '0;
        entWrite[i] <= 1'b0;
        entLanes[i] <= '0;
        entDummy[i] <= '0;
      end
    end else begin
      progErr <= progEn && reject;
      if (progEn && !reject) begin
        entValid[freeIdx] <= 1'b1;
        entOp[freeIdx]    <= progOpcode;
        entMode[freeIdx]  <= progAddrMode;
        entWrite[freeIdx] <= progWrite;
        entLanes[freeIdx] <= progLanes;
        entDummy[freeIdx] <= progDummy;
      end
    end
  end

  // Parallel compare lines
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hitVec[g] = entValid[g] && (entOp[g] == lkOpcode);
  end

  assign lkHit = |hitVec;

  // At most one line matches, so OR-merging the selected fields is exact.
  always_comb begin
    lkMode  = '0;
    lkWrite = 1'b0;
    lkLanes = '0;
    lkDummy = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hitVec[i]) begin
        lkMode  = lkMode  | entMode[i];
        lkWrite = lkWrite | entWrite[i];
        lkLanes = lkLanes | entLanes[i];
        lkDummy = lkDummy | entDummy[i];
      end
    end
  end

endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [7:0]         byteData,
  input  logic               addr4bEn,
  input  logic               lkHit,
  input  logic [1:0]         lkMode,
  input  logic               lkWrite,
  input  logic [1:0]         lkLanes,
  input  logic [DUMMY_W-1:0] lkDummy,
  output logic               nextHasAddr,
  output logic               nextDummyZero,
  output logic               addrLast,
  output logic               dummyZero,
  output logic               dummyLast,
  output logic [31:0]        addrOut,
  output logic [2:0]         dataLanes,
  output logic               isWrite
);

  localparam int MAX_ADDR_BYTES = 4;
  localparam int CNT_W          = $clog2(MAX_ADDR_BYTES + 1);

  logic [CNT_W-1:0]   nextAddrBytes;
  logic               effWrite;
  logic [1:0]         effLanes;
  logic [DUMMY_W-1:0] effDummy;

  logic [31:0]        addrReg;
  logic [CNT_W-1:0]   addrLeft;
  logic [DUMMY_W-1:0] dummyCnt;
  logic               wrReg;
  logic [1:0]         laneReg;

  // Command attributes, with fixed fallbacks for a miss
  always_comb begin
    nextAddrBytes = '0;
    if (lkHit) begin
      unique case (addr_mode_e'(lkMode))
        AM_NONE:     nextAddrBytes = CNT_W'(0);
        AM_SWITCHED: nextAddrBytes = addr4bEn ? CNT_W'(4) : CNT_W'(3);
        AM_THREE:    nextAddrBytes = CNT_W'(3);
        AM_FOUR:     nextAddrBytes = CNT_W'(4);
        default:     nextAddrBytes = CNT_W'(0);
      endcase
    end
  end

  assign effWrite      = lkHit ? lkWrite : 1'b1;
  assign effLanes      = lkHit ? lkLanes : 2'd0;
  assign effDummy      = lkHit ? lkDummy : '0;
  assign nextHasAddr   = (nextAddrBytes != '0);
  assign nextDummyZero = (effDummy == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      addrLeft <= '0;
      dummyCnt <= '0;
      wrReg    <= 1'b0;
      laneReg  <= '0;
    end else if (strobe.latchCmd) begin
      addrReg  <= '0;
      addrLeft <= nextAddrBytes;
      dummyCnt <= effDummy;
      wrReg    <= effWrite;
      laneReg  <= effLanes;
    end else begin
      if (strobe.shiftAddr) begin
        addrReg  <= {addrReg[23:0], byteData};
        addrLeft <= addrLeft - CNT_W'(1);
      end
      if (strobe.tickDummy) begin
        dummyCnt <= dummyCnt - DUMMY_W'(1);
      end
    end
  end

  assign addrLast  = (addrLeft == CNT_W'(1));
  assign dummyZero = (dummyCnt == '0);
  assign dummyLast = (dummyCnt == DUMMY_W'(1));
  assign addrOut   = addrReg;
  assign dataLanes = 3'b001 << laneReg;
  assign isWrite   = wrReg;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    byteValid,
  input  logic    nextHasAddr,
  input  logic    nextDummyZero,
  input  logic    addrLast,
  input  logic    dummyZero,
  input  logic    dummyLast,
  output phase_e  phase,
  output strobe_t strobe
);

  phase_e phaseNext;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    if (csN) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: phaseNext = PH_OPCODE;
        PH_OPCODE: begin
          if (byteValid) begin
            strobe.latchCmd = 1'b1;
            if (nextHasAddr)        phaseNext = PH_ADDR;
            else if (!nextDummyZero) phaseNext = PH_DUMMY;
            else                     phaseNext = PH_DATA;
          end
        end
        PH_ADDR: begin
          if (byteValid) begin
            strobe.shiftAddr = 1'b1;
            if (addrLast) phaseNext = dummyZero ? PH_DATA : PH_DUMMY;
          end
        end
        PH_DUMMY: begin
          strobe.tickDummy = 1'b1;
          if (dummyLast) phaseNext = PH_DATA;
        end
        PH_DATA: phaseNext = PH_DATA;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               progEn,
  input  logic [7:0]         progOpcode,
  input  logic [1:0]         progAddrMode,
  input  logic               progWrite,
  input  logic [1:0]         progLanes,
  input  logic [DUMMY_W-1:0] progDummy,
  output logic               progErr,
  input  logic               csN,
  input  logic               byteValid,
  input  logic [7:0]         byteData,
  input  logic               addr4bEn,
  output logic [2:0]         phase,
  output logic [31:0]        addrOut,
  output logic [2:0]         dataLanes,
  output logic               isWrite
);

  logic [DEPTH-1:0]   hitVec;
  logic               lkHit;
  logic [1:0]         lkMode;
  logic               lkWrite;
  logic [1:0]         lkLanes;
  logic [DUMMY_W-1:0] lkDummy;
  logic               nextHasAddr;
  logic               nextDummyZero;
  logic               addrLast;
  logic               dummyZero;
  logic               dummyLast;
  strobe_t            strobe;
  phase_e             phaseState;

  flash_cmd_table #(.DEPTH(DEPTH), .DUMMY_W(DUMMY_W)) u_table (
    .clk(clk), .rstN(rstN),
    .progEn(progEn), .progOpcode(progOpcode), .progAddrMode(progAddrMode),
    .progWrite(progWrite), .progLanes(progLanes), .progDummy(progDummy),
    .progErr(progErr), .lkOpcode(byteData), .hitVec(hitVec), .lkHit(lkHit),
    .lkMode(lkMode), .lkWrite(lkWrite), .lkLanes(lkLanes), .lkDummy(lkDummy)
  );

  flash_cmd_datapath #(.DUMMY_W(DUMMY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .addr4bEn(addr4bEn), .lkHit(lkHit), .lkMode(lkMode), .lkWrite(lkWrite),
    .lkLanes(lkLanes), .lkDummy(lkDummy), .nextHasAddr(nextHasAddr),
    .nextDummyZero(nextDummyZero), .addrLast(addrLast), .dummyZero(dummyZero),
    .dummyLast(dummyLast), .addrOut(addrOut), .dataLanes(dataLanes),
    .isWrite(isWrite)
  );

  flash_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .byteValid(byteValid),
    .nextHasAddr(nextHasAddr), .nextDummyZero(nextDummyZero),
    .addrLast(addrLast), .dummyZero(dummyZero), .dummyLast(dummyLast),
    .phase(phaseState), .strobe(strobe)
  );

  assign phase = phaseState;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             byteValid,
  input logic             progEn,
  input logic             progErr,
  input logic [2:0]       phase,
  input logic [31:0]      addrOut,
  input logic [2:0]       dataLanes,
  input logic             isWrite,
  input logic [DEPTH-1:0] hitVec,
  input logic             lkHit
);

  // R2
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (phase == 3'd0));

  // R2
  cs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd0 && !csN) |=> (phase == 3'd1));

  // R3
  unique_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R3
  err_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !progEn |=> !progErr);

  // R10
  miss_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd1 && byteValid && !csN && !lkHit)
      |=> (isWrite && dataLanes == 3'd1 && phase == 3'd4));

  // R11
  lane_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(dataLanes) == 1);

  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd0 || phase == 3'd3 || phase == 3'd4) |=> $stable(addrOut));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .byteValid(byteValid),
  .progEn(progEn), .progErr(progErr), .phase(phase), .addrOut(addrOut),
  .dataLanes(dataLanes), .isWrite(isWrite), .hitVec(hitVec), .lkHit(lkHit)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        progEn = 1'b0;
  logic [7:0]  progOpcode = '0;
  logic [1:0]  progAddrMode = '0;
  logic        progWrite = 1'b0;
  logic [1:0]  progLanes = '0;
  logic [4:0]  progDummy = '0;
  logic        progErr;
  logic        csN = 1'b1;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        addr4bEn = 1'b0;
  logic [2:0]  phase;
  logic [31:0] addrOut;
  logic [2:0]  dataLanes;
  logic        isWrite;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .progEn(progEn), .progOpcode(progOpcode),
    .progAddrMode(progAddrMode), .progWrite(progWrite), .progLanes(progLanes),
    .progDummy(progDummy), .progErr(progErr), .csN(csN), .byteValid(byteValid),
    .byteData(byteData), .addr4bEn(addr4bEn), .phase(phase), .addrOut(addrOut),
    .dataLanes(dataLanes), .isWrite(isWrite)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic        a4;
    logic [31:0] addr;
    logic [2:0]  nb;
    logic [4:0]  dum;
    logic [2:0]  lanes;
    logic        wr;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'h03, 1'b0, 32'h0012_3456, 3'd3, 5'd0, 3'd1, 1'b0},
    '{8'h0B, 1'b1, 32'h00AB_CDEF, 3'd3, 5'd8, 3'd1, 1'b0},
    '{8'h3B, 1'b0, 32'h00A1_B2C3, 3'd3, 5'd8, 3'd2, 1'b0},
    '{8'h3B, 1'b1, 32'hDEAD_BEEF, 3'd4, 5'd8, 3'd2, 1'b0},
    '{8'h6B, 1'b0, 32'h0102_0304, 3'd4, 5'd1, 3'd4, 1'b0},
    '{8'h06, 1'b0, 32'h0000_0000, 3'd0, 5'd0, 3'd1, 1'b1},
    '{8'h9F, 1'b1, 32'h0000_0000, 3'd0, 5'd3, 3'd1, 1'b0},
    '{8'hFF, 1'b0, 32'h0000_0000, 3'd0, 5'd0, 3'd1, 1'b1},
    '{8'h02, 1'b1, 32'h89AB_CDEF, 3'd4, 5'd0, 3'd1, 1'b1}
  };

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic prog(input logic [7:0] op, input logic [1:0] mode, input logic wr,
                      input logic [1:0] lane, input logic [4:0] dum, input logic expErr,
                      input string tag);
    @(negedge clk);
    progEn = 1'b1; progOpcode = op; progAddrMode = mode;
    progWrite = wr; progLanes = lane; progDummy = dum;
    @(negedge clk);
    progEn = 1'b0;
    check(tag, {31'd0, progErr}, {31'd0, expErr});
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1; byteData = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic selectLow();
    @(negedge clk);
    csN = 1'b0;
    @(negedge clk);
    check("R2 opcode phase after select", {29'd0, phase}, 32'd1);
  endtask

  task automatic selectHigh();
    @(negedge clk);
    csN = 1'b1;
    @(negedge clk);
    check("R2 idle after deselect", {29'd0, phase}, 32'd0);
  endtask

  function automatic logic [2:0] phaseAfterOp(input logic [2:0] nb, input logic [4:0] dum);
    if (nb != 0)       return 3'd2;
    else if (dum != 0) return 3'd3;
    else               return 3'd4;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int dcnt;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 phase", {29'd0, phase}, 32'd0);
    check("R1 addrOut", addrOut, 32'd0);
    check("R1 dataLanes", {29'd0, dataLanes}, 32'd1);
    check("R1 isWrite", {31'd0, isWrite}, 32'd0);
    check("R1 progErr", {31'd0, progErr}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {29'd0, phase}, 32'd0);

    // Table programming
    prog(8'h03, 2'd2, 1'b0, 2'd0, 5'd0, 1'b0, "R3 accept 03");
    prog(8'h0B, 2'd2, 1'b0, 2'd0, 5'd8, 1'b0, "R3 accept 0B");
    prog(8'h3B, 2'd1, 1'b0, 2'd1, 5'd8, 1'b0, "R3 accept 3B");
    prog(8'h6B, 2'd3, 1'b0, 2'd2, 5'd1, 1'b0, "R3 accept 6B");
    prog(8'h06, 2'd0, 1'b1, 2'd0, 5'd0, 1'b0, "R3 accept 06");
    prog(8'h9F, 2'd0, 1'b0, 2'd0, 5'd3, 1'b0, "R3 accept 9F");
    prog(8'h02, 2'd1, 1'b1, 2'd0, 5'd0, 1'b0, "R3 accept 02");
    prog(8'h03, 2'd3, 1'b1, 2'd2, 5'd4, 1'b1, "R3 duplicate refused");
    prog(8'h55, 2'd2, 1'b0, 2'd3, 5'd0, 1'b1, "R5 lane code 3 refused");

    // Vector walk (R6 R7 R8 R9 R10 R11 R12); 03 entry confirms R3 duplicate had no effect
    for (int v = 0; v < NVEC; v++) begin
      addr4bEn = VECS[v].a4;
      selectLow();
      sendByte(VECS[v].op);
      check("R6 phase after opcode", {29'd0, phase},
            {29'd0, phaseAfterOp(VECS[v].nb, VECS[v].dum)});
      check("R8 address cleared at opcode", addrOut, 32'd0);
      for (int k = 0; k < VECS[v].nb; k++) begin
        sendByte(8'(VECS[v].addr >> (8 * (VECS[v].nb - 1 - k))));
        check("R8 address shift", addrOut,
              VECS[v].addr >> (8 * (VECS[v].nb - 1 - k)));
      end
      dcnt = 0;
      while (phase == 3'd3 && dcnt < 40) begin
        if (dcnt == 0) begin
          @(negedge clk);
          byteValid = 1'b1; byteData = 8'h5A;
          held = addrOut;
        end else begin
          @(negedge clk);
        end
        byteValid = 1'b0;
        dcnt++;
      end
      check("R9 dummy length", dcnt, {27'd0, VECS[v].dum});
      if (VECS[v].dum != 0) check("R12 dummy byte ignored", addrOut, VECS[v].addr);
      check("R6 data phase", {29'd0, phase}, 32'd4);
      check("R7 R8 final address", addrOut, VECS[v].addr);
      check("R11 R10 lanes", {29'd0, dataLanes}, {29'd0, VECS[v].lanes});
      check("R11 R10 direction", {31'd0, isWrite}, {31'd0, VECS[v].wr});
      sendByte(8'hC3);
      check("R12 data byte keeps address", addrOut, VECS[v].addr);
      check("R12 data byte keeps phase", {29'd0, phase}, 32'd4);
      selectHigh();
    end

    // R12: byte in idle ignored
    held = addrOut;
    sendByte(8'h77);
    check("R12 idle byte keeps address", addrOut, held);
    check("R12 idle byte keeps phase", {29'd0, phase}, 32'd0);

    // R5: refused lane-3 opcode behaves as a miss
    selectLow();
    sendByte(8'h55);
    check("R5 refused entry absent phase", {29'd0, phase}, 32'd4);
    check("R5 refused entry absent write", {31'd0, isWrite}, 32'd1);
    selectHigh();

    // R4: fill remaining slots then overflow
    for (int k = 0; k < 9; k++) begin
      prog(8'hA0 + 8'(k), 2'd0, 1'b0, 2'd1, 5'd0, 1'b0, "R4 fill slot");
    end
    prog(8'hC0, 2'd0, 1'b0, 2'd2, 5'd0, 1'b1, "R4 full table refused");
    selectLow();
    sendByte(8'hA8);
    check("R4 last slot lanes", {29'd0, dataLanes}, 32'd2);
    check("R4 last slot read", {31'd0, isWrite}, 32'd0);
    selectHigh();
    selectLow();
    sendByte(8'hC0);
    check("R4 overflow entry absent", {31'd0, isWrite}, 32'd1);
    check("R4 overflow entry lanes", {29'd0, dataLanes}, 32'd1);
    selectHigh();

    // R2: abort in the middle of the address phase
    selectLow();
    sendByte(8'h03);
    sendByte(8'h11);
    check("R2 still in address phase", {29'd0, phase}, 32'd2);
    selectHigh();
    selectLow();
    sendByte(8'h06);
    check("R2 fresh command after abort", {29'd0, phase}, 32'd4);
    check("R8 cleared after abort", addrOut, 32'd0);
    selectHigh();

    finishRun();
  end

endmodule